// File: doc/BRIEF.md
# Banked Host Register Window with Pointer-Addressed Buffer Port

This block is the host-side register window of a packet network controller. A byte-wide host bus reaches sixteen byte offsets. Offsets 14 and 15 are visible from every bank. The other fourteen offsets are decoded in one of four banks, and the host picks the bank by writing a bank-select byte. The block holds a small set of plain storage registers and two read-only identity bytes. It also holds the registers that address the packet buffer: a packet-number byte and a 16-bit pointer.

Four byte offsets in bank 2 form a data window into the buffer memory. Each access in the window drives the buffer port in the same cycle, with a page number and an 11-bit byte offset. Two pointer flags decide how the window behaves. One flag picks the page: either the head of the receive queue, which arrives on an input, or the packet-number register. The other flag picks the addressing mode. In auto-step mode the 11-bit offset field of the pointer advances on every access. In fixed mode the low two address bits are added to the offset and the pointer is left alone. The receive queue, the interrupt logic and the meaning of the storage registers sit outside this block.

Top module: `nic_regwin`

## Requirements
- R1: A write to offset 14 in any bank stores host_wdata[1:0] as the bank number. A read of offset 14 returns {6'b0, bank}. The bank is 0 after reset.
- R2: A read of offset 15 returns 0x33 in every bank. A write to offset 15 changes nothing and raises no error.
- R3: The pointer is in bank 2. Offset 6 holds bits [7:0] and offset 7 holds bits [15:8]. Each byte write replaces only its own half. A read of offset 7 returns pointer[15:8] & 0xF7. The pointer is 0 after reset.
- R4: The data window is bank 2, offsets 8 to 11. When pointer bit 15 is 1, buf_page equals rxq_head. Otherwise buf_page equals the low PAGE_W bits of the packet-number byte (bank 2 offset 2, read/write, reset 0).
- R5: When pointer bit 14 is 1, buf_off equals pointer[10:0]. Each data-window read or write then adds 1 to pointer[10:0] modulo 2048 and leaves pointer[15:11] unchanged.
- R6: When pointer bit 14 is 0, buf_off equals (pointer[10:0] + host_addr[1:0]) modulo 2048, and a data-window access leaves the pointer unchanged.
- R7: The byte storage registers read back the last byte written and reset to 0. The pairs are: bank 0 offsets 0/1 and 4/5, bank 1 offsets 0/1, 10/11 and 12/13, and bank 3 offset 12 (a single byte).
- R8: A write byte with host_wide=1, which marks a byte of a 32-bit write, is discarded without error when its offset is 12 or 13. Wide bytes to offsets 14 and 15 act as normal writes.
- R9: Bank 3 offset 10 reads 0x91. Bank 0 offset 8 reads NUM_PAGES (4 by default).
- R10: A read or write of an undefined offset (in the plain sense, or a write to a read-only byte) returns 0 on reads, changes no state, and sets host_err for exactly one cycle.
- R11: host_rdata, host_rvalid and host_err are due in the cycle after the access. The buffer port (buf_we, buf_re, buf_page, buf_off, buf_wdata) is driven in the access cycle itself, and buf_rdata is expected one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe (wins over host_rd) |
| host_rd | input | 1 | Host byte read strobe |
| host_wide | input | 1 | Byte belongs to a 32-bit write |
| host_addr | input | 4 | Byte offset in the window |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, one cycle after host_rd |
| host_rvalid | output | 1 | host_rdata valid |
| host_err | output | 1 | One-cycle pulse after an undefined access |
| rxq_head | input | PAGE_W | Page at the head of the receive queue |
| buf_page | output | PAGE_W | Buffer page of the current window access |
| buf_off | output | 11 | Buffer byte offset |
| buf_we | output | 1 | Buffer byte write |
| buf_re | output | 1 | Buffer byte read |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte, one cycle after buf_re |

## Verification
The buffer address and strobes are combinational from the current access, so the bench samples them one time step after it drives the access, inside the same cycle. Read data, the valid flag and the error flag pass through one register. The bench therefore samples them at the falling edge after the access edge, before it drives the next access. Pointer changes from auto-stepping show up on the next access, and the bench checks them through its own model of the pointer and through pointer reads at offsets 6 and 7.

// File: rtl/nic_regwin_pkg.sv
package nic_regwin_pkg;

  localparam int OFF_W        = 11;
  localparam int PTR_SEL_BIT  = 15;
  localparam int PTR_STEP_BIT = 14;

  typedef enum logic [3:0] {
    K_NONE, K_BANK, K_FIX, K_WORD, K_MEMSZ, K_PKT, K_PTR, K_DATA, K_REV
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] widx;
    logic       hi;
    logic       rd_ok;
    logic       wr_ok;
  } dec_t;

  // Buffer byte offset addressed by a window access.
  function automatic logic [OFF_W-1:0] win_offset(input logic [15:0] ptr,
                                                  input logic [1:0]  lane);
    if (ptr[PTR_STEP_BIT]) return ptr[OFF_W-1:0];
    return ptr[OFF_W-1:0] + OFF_W'(lane);
  endfunction

  // Pointer after an auto-step access: only the offset field wraps.
  function automatic logic [15:0] ptr_step(input logic [15:0] ptr);
    logic [OFF_W-1:0] nxt;
    nxt = ptr[OFF_W-1:0] + OFF_W'(1);
    return {ptr[15:OFF_W], nxt};
  endfunction

endpackage

// File: rtl/nic_regwin_dec.sv
module nic_regwin_dec
  import nic_regwin_pkg::*;
(
  input  logic [1:0] bank,
  input  logic [3:0] addr,
  output dec_t       dec
);
  always_comb begin
    dec = '{kind: K_NONE, widx: 3'd0, hi: addr[0], rd_ok: 1'b0, wr_ok: 1'b0};
    if (addr == 4'd14) begin
      dec.kind = K_BANK; dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
    end else if (addr == 4'd15) begin
      dec.kind = K_FIX;  dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
    end else begin
      unique case (bank)
        2'd0: begin
          if (addr[3:1] == 3'd0) begin dec.kind = K_WORD; dec.widx = 3'd0; end
          if (addr[3:1] == 3'd2) begin dec.kind = K_WORD; dec.widx = 3'd1; end
          if (addr == 4'd8)      dec.kind = K_MEMSZ;
        end
        2'd1: begin
          if (addr[3:1] == 3'd0) begin dec.kind = K_WORD; dec.widx = 3'd2; end
          if (addr[3:1] == 3'd5) begin dec.kind = K_WORD; dec.widx = 3'd3; end
          if (addr[3:1] == 3'd6) begin dec.kind = K_WORD; dec.widx = 3'd4; end
        end
        2'd2: begin
          if (addr == 4'd2)      dec.kind = K_PKT;
          if (addr[3:1] == 3'd3) dec.kind = K_PTR;
          if (addr[3:2] == 2'd2) dec.kind = K_DATA;
        end
        default: begin
          if (addr == 4'd10) dec.kind = K_REV;
          if (addr == 4'd12) begin dec.kind = K_WORD; dec.widx = 3'd5; end
        end
      endcase
      dec.rd_ok = (dec.kind != K_NONE);
      dec.wr_ok = (dec.kind != K_NONE) && (dec.kind != K_MEMSZ) && (dec.kind != K_REV);
    end
  end
endmodule

// File: rtl/nic_regwin_ptr.sv
module nic_regwin_ptr
  import nic_regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [7:0]       wdata,
  input  logic             data_acc,
  input  logic [1:0]       lane,
  output logic [15:0]      ptr_q,
  output logic [OFF_W-1:0] offset
);
  assign offset = win_offset(ptr_q, lane);

  always_ff @(posedge clk) begin
    if (!rst_n)                             ptr_q <= '0;
    else if (we_lo)                         ptr_q <= {ptr_q[15:8], wdata};
    else if (we_hi)                         ptr_q <= {wdata, ptr_q[7:0]};
    else if (data_acc && ptr_q[PTR_STEP_BIT]) ptr_q <= ptr_step(ptr_q);
  end
endmodule

// File: rtl/nic_regwin_store.sv
module nic_regwin_store #(
  parameter int NWORDS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [2:0]             widx,
  input  logic                   hi,
  input  logic [7:0]             wdata,
  output logic [NWORDS-1:0][15:0] words
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (we && widx == 3'(g)) begin
        if (hi) words[g][15:8] <= wdata;
        else    words[g][7:0]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/nic_regwin.sv
module nic_regwin
  import nic_regwin_pkg::*;
#(
  parameter int          NUM_PAGES = 4,
  parameter logic [7:0]  REV_ID    = 8'h91,
  parameter int          PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_wide,
  input  logic [3:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  output logic              host_err,
  input  logic [PAGE_W-1:0] rxq_head,
  output logic [PAGE_W-1:0] buf_page,
  output logic [OFF_W-1:0]  buf_off,
  output logic              buf_we,
  output logic              buf_re,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata
);
  localparam int BANK_W = 2;
  localparam int NWORDS = 6;

  dec_t                    dec;
  logic [BANK_W-1:0]       bank_q;
  logic [7:0]              pkt_q;
  logic [15:0]             ptr_q;
  logic [NWORDS-1:0][15:0] words;
  logic                    wr_drop, eff_wr, eff_rd, bad_acc, data_acc;
  logic [7:0]              rd_val, rdata_q;
  logic                    sel_buf_q;

  nic_regwin_dec u_dec (.bank(bank_q), .addr(host_addr), .dec(dec));

  // Bytes 12/13 of a 32-bit write are dropped; the bus only means 14/15.
  assign wr_drop  = host_wr && host_wide && (host_addr[3:1] == 3'd6);
  assign eff_wr   = host_wr && !wr_drop && dec.wr_ok;
  assign eff_rd   = host_rd && !host_wr && dec.rd_ok;
  assign bad_acc  = (host_wr && !wr_drop && !dec.wr_ok) || (host_rd && !host_wr && !dec.rd_ok);
  assign data_acc = (eff_wr || eff_rd) && (dec.kind == K_DATA);

  nic_regwin_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .we_lo(eff_wr && dec.kind == K_PTR && !dec.hi),
    .we_hi(eff_wr && dec.kind == K_PTR &&  dec.hi),
    .wdata(host_wdata), .data_acc(data_acc), .lane(host_addr[1:0]),
    .ptr_q(ptr_q), .offset(buf_off)
  );

  nic_regwin_store #(.NWORDS(NWORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(eff_wr && dec.kind == K_WORD), .widx(dec.widx), .hi(dec.hi),
    .wdata(host_wdata), .words(words)
  );

  assign buf_page  = ptr_q[PTR_SEL_BIT] ? rxq_head : pkt_q[PAGE_W-1:0];
  assign buf_we    = data_acc && host_wr;
  assign buf_re    = data_acc && !host_wr;
  assign buf_wdata = host_wdata;

  always_comb begin
    unique case (dec.kind)
      K_BANK:  rd_val = 8'(bank_q);
      K_FIX:   rd_val = 8'h33;
      K_WORD:  rd_val = dec.hi ? words[dec.widx][15:8] : words[dec.widx][7:0];
      K_MEMSZ: rd_val = 8'(NUM_PAGES);
      K_PKT:   rd_val = pkt_q;
      K_PTR:   rd_val = dec.hi ? (ptr_q[15:8] & 8'hF7) : ptr_q[7:0];
      K_REV:   rd_val = REV_ID;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0; pkt_q <= '0; rdata_q <= '0; sel_buf_q <= 1'b0;
      host_rvalid <= 1'b0; host_err <= 1'b0;
    end else begin
      if (eff_wr && dec.kind == K_BANK) bank_q <= host_wdata[BANK_W-1:0];
      if (eff_wr && dec.kind == K_PKT)  pkt_q  <= host_wdata;
      rdata_q     <= eff_rd ? rd_val : 8'h00;
      sel_buf_q   <= buf_re;
      host_rvalid <= host_rd && !host_wr;
      host_err    <= bad_acc;
    end
  end

  assign host_rdata = sel_buf_q ? buf_rdata : rdata_q;
endmodule

// File: rtl/nic_regwin_chk.sv
module nic_regwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic [3:0]  host_addr,
  input logic        host_err,
  input logic        host_rvalid,
  input logic        buf_we,
  input logic        buf_re,
  input logic [15:0] ptr_q,
  input logic [1:0]  bank_q,
  input logic        data_acc
);
  AST_PTR_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && ptr_q[14] |=> ptr_q[10:0] == 11'($past(ptr_q[10:0]) + 11'd1)
                           && ptr_q[15:11] == $past(ptr_q[15:11])); // R5
  AST_PTR_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !ptr_q[14] |=> $stable(ptr_q)); // R6
  AST_BANK_ONLY_BY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 4'd14) |=> $stable(bank_q)); // R1
  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr || host_rd) |=> !host_err); // R10
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr |=> host_rvalid); // R11
  AST_BUF_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && buf_re)); // R11
endmodule

bind nic_regwin nic_regwin_chk u_chk (.*);

// File: tb/tb_nic_regwin.sv
module tb_nic_regwin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_wide = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid, host_err;
  logic [1:0] rxq_head = '0;
  logic [1:0] buf_page;
  logic [10:0] buf_off;
  logic       buf_we, buf_re;
  logic [7:0] buf_wdata;
  logic [7:0] buf_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nic_regwin dut (.*);

  function automatic logic [7:0] mem_val(input logic [1:0] pg, input logic [10:0] off);
    return off[7:0] ^ {pg, 3'b101, off[10:8]};
  endfunction

  always @(posedge clk) if (buf_re) buf_rdata <= mem_val(buf_page, buf_off);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  logic [1:0]  cap_page;
  logic [10:0] cap_off;
  logic        cap_we, cap_re;
  logic [7:0]  cap_wd;

  task automatic acc(input bit w, input logic [3:0] a, input logic [7:0] d, input bit wide,
                     output logic [7:0] rdv, output logic err, output logic rv);
    @(negedge clk);
    host_wr = w; host_rd = !w; host_addr = a; host_wdata = d; host_wide = wide;
    #1;
    cap_page = buf_page; cap_off = buf_off; cap_we = buf_we; cap_re = buf_re; cap_wd = buf_wdata;
    @(negedge clk);
    host_wr = 0; host_rd = 0; host_wide = 0;
    rdv = host_rdata; err = host_err; rv = host_rvalid;
  endtask

  logic [7:0] r; logic e, v;

  task automatic wr(input logic [3:0] a, input logic [7:0] d); acc(1, a, d, 0, r, e, v); endtask
  task automatic rd(input logic [3:0] a);                     acc(0, a, 8'h00, 0, r, e, v); endtask

  logic [15:0] mptr;
  logic [7:0]  mpkt;

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    rd(4'd14); chk(r == 8'h00 && !e && v, "R1 reset bank", r, 0);
    wr(4'd14, 8'hFE); rd(4'd14); chk(r == 8'h02, "R1 bank select low bits", r, 2);
    rd(4'd6); chk(r == 8'h00, "R3 reset ptr", r, 0);
    wr(4'd14, 8'h00); rd(4'd0); chk(r == 8'h00, "R7 reset storage", r, 0);
    // R2 fixed offset 15
    for (int b = 0; b < 4; b++) begin
      wr(4'd14, 8'(b)); rd(4'd15); chk(r == 8'h33, "R2 offset 15 read", r, 8'h33);
      wr(4'd15, 8'hAA); chk(!e, "R2 offset 15 write no error", e, 0);
      rd(4'd14); chk(r == 8'(b), "R2 write 15 keeps bank", r, b);
    end
    // R7 storage
    wr(4'd14, 8'd0); wr(4'd0, 8'h5A); wr(4'd1, 8'hC3);
    rd(4'd0); chk(r == 8'h5A, "R7 bank0 low byte", r, 8'h5A);
    rd(4'd1); chk(r == 8'hC3, "R7 bank0 high byte", r, 8'hC3);
    wr(4'd14, 8'd1); wr(4'd11, 8'h77); rd(4'd11); chk(r == 8'h77, "R7 bank1 word", r, 8'h77);
    rd(4'd10); chk(r == 8'h00, "R7 other half kept", r, 0);
    // R9 fixed values
    wr(4'd14, 8'd0); rd(4'd8); chk(r == 8'd4, "R9 page count", r, 4);
    wr(4'd14, 8'd3); rd(4'd10); chk(r == 8'h91, "R9 revision", r, 8'h91);
    // R10 undefined
    wr(4'd10, 8'h12); chk(e, "R10 write read-only errs", e, 1);
    rd(4'd10); chk(r == 8'h91 && !e, "R10 read-only unchanged", r, 8'h91);
    wr(4'd14, 8'd0); rd(4'd3); chk(r == 8'h00 && e, "R10 undefined read", r, 0);
    wr(4'd3, 8'hFF); chk(e, "R10 undefined write errs", e, 1);
    rd(4'd0); chk(!e && r == 8'h5A, "R10 one-cycle pulse", e, 0);
    // R8 wide write
    wr(4'd14, 8'd2);
    acc(1, 4'd12, 8'h11, 1, r, e, v); chk(!e, "R8 wide byte 12 dropped", e, 0);
    acc(1, 4'd13, 8'h22, 1, r, e, v); chk(!e, "R8 wide byte 13 dropped", e, 0);
    acc(1, 4'd14, 8'h01, 1, r, e, v); acc(1, 4'd15, 8'h44, 1, r, e, v);
    rd(4'd14); chk(r == 8'h01, "R8 wide byte 14 applied", r, 1);
    wr(4'd14, 8'd2); acc(1, 4'd12, 8'h11, 0, r, e, v); chk(e, "R8 narrow byte 12 undefined", e, 1);
    // R3 pointer halves and mask
    wr(4'd6, 8'hA5); wr(4'd7, 8'h0F);
    rd(4'd7); chk(r == 8'h07, "R3 high mask", r, 7);
    rd(4'd6); chk(r == 8'hA5, "R3 low byte", r, 8'hA5);
    // R5 wrap directed
    wr(4'd2, 8'h03); wr(4'd6, 8'hFF); wr(4'd7, 8'h47); rxq_head = 2'd1;
    rd(4'd9); chk(cap_off == 11'h7FF && cap_page == 2'd3, "R5 auto offset", cap_off, 11'h7FF);
    chk(r == mem_val(2'd3, 11'h7FF) && v, "R11 buffer read data", r, mem_val(2'd3, 11'h7FF));
    rd(4'd6); chk(r == 8'h00, "R5 wrap low", r, 0);
    rd(4'd7); chk(r == 8'h40, "R5 wrap keeps high flags", r, 8'h40);
    // R6 fixed mode wrap
    wr(4'd6, 8'hFF); wr(4'd7, 8'h87);
    wr(4'd11, 8'h9C);
    chk(cap_we && cap_off == 11'h002 && cap_page == 2'd1 && cap_wd == 8'h9C, "R6 fixed lane add", cap_off, 2);
    rd(4'd6); chk(r == 8'hFF, "R6 pointer unchanged", r, 8'hFF);
    // Random window traffic
    mptr = 16'h87FF; mpkt = 8'h03;
    for (int i = 0; i < 400; i++) begin
      int op; op = $urandom_range(0, 5);
      if (op == 0) begin
        logic [7:0] d; d = 8'($urandom); wr(4'd6, d); mptr[7:0] = d;
      end else if (op == 1) begin
        logic [7:0] d; d = 8'($urandom); wr(4'd7, d); mptr[15:8] = d;
      end else if (op == 2) begin
        logic [7:0] d; d = 8'($urandom); wr(4'd2, d); mpkt = d;
        rd(4'd2); chk(r == d, "R4 packet number readback", r, d);
      end else begin
        logic [1:0] ln; logic [1:0] pg; logic [10:0] off; bit w;
        rxq_head = 2'($urandom); ln = 2'($urandom); w = (op == 5);
        pg  = mptr[15] ? rxq_head : mpkt[1:0];
        off = mptr[14] ? mptr[10:0] : 11'(mptr[10:0] + 11'(ln));
        acc(w, {2'b10, ln}, 8'(i), 0, r, e, v);
        chk(cap_page == pg, "R4 page select", cap_page, pg);
        chk(cap_off == off, mptr[14] ? "R5 auto offset" : "R6 fixed offset", cap_off, off);
        chk(cap_we == w && cap_re == !w, "R11 buffer strobes", cap_we, w);
        if (!w) chk(r == mem_val(pg, off), "R11 window read data", r, mem_val(pg, off));
        if (mptr[14]) mptr[10:0] = mptr[10:0] + 11'd1;
        rd(4'd6); chk(r == mptr[7:0], "R5 pointer after access", r, mptr[7:0]);
        rd(4'd7); chk(r == (mptr[15:8] & 8'hF7), "R3 pointer high after access", r, mptr[15:8] & 8'hF7);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule